// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block sits on the host side of an 8192-byte, byte-wide parallel EEPROM. It receives commands over a valid/ready interface. A read command performs one timed read cycle and returns the byte. A write command streams 1 to 64 bytes into one page of the memory, then waits for the memory's self-timed program cycle to end.

Every pin timing is held for a number of clock cycles computed from nanosecond parameters and the clock period. Completion of programming is detected in one of two ways, chosen per command. The first watches the open-drain ready/busy line, which has an external pull-up, so high means ready. The second repeatedly reads the last written location and compares data bit 7 with the value that was written. A timeout counter bounds the wait, and a write that does not finish in time is answered with an error flag.

The host supplies page data one byte at a time on `wdat`. The controller pulses `wdat_take` in the cycle after it has latched a byte, and the host then presents the next byte.

Top module: `eep_page_ctl`

## Requirements
- R1: During and after reset, `cmd_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: A read (`cmd_write`=0) holds CE low, OE low and WE high for at least ceil(T_ACC_NS/CLK_NS) cycles at `cmd_addr`. It then returns the byte seen on `mem_dq_i` in `rsp_rdata`, with `rsp_err`=0.
- R3: Each byte of a write is driven with `mem_dq_oe`=1 while CE is low and OE is high. The WE low pulse lasts at least ceil(T_WP_NS/CLK_NS) cycles, and `wdat_take` pulses exactly once per byte.
- R4: Within a write burst, address bits 12..6 stay equal to those of `cmd_addr`. Bits 5..0 start at `cmd_addr[5:0]` and increase by one per byte, wrapping from 63 to 0.
- R5: A write command whose `cmd_len` is 0 or greater than 64 is answered in the next cycle with `rsp_valid`=1 and `rsp_err`=1, and CE never falls for it.
- R6: With `poll_mode`=0, the response to a write comes only after the memory's ready/busy line is high (ready) again, with `rsp_err`=0.
- R7: With `poll_mode`=1, the controller issues repeated reads. It responds with `rsp_err`=0 only after I/O7 reads equal to bit 7 of the last byte written.
- R8: If completion is not seen within TIMEOUT_NS after the last byte, the response carries `rsp_err`=1 and the controller returns to idle (`cmd_ready`=1).
- R9: `mem_dq_oe` is never 1 while OE is low. It also stays 0 for at least ceil(T_DF_NS/CLK_NS) cycles after OE rises.
- R10: `cmd_ready` is 1 only when idle, and each accepted command produces exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command accepted when valid |
| cmd_write | input | 1 | 1 = page write, 0 = read |
| cmd_addr | input | 13 | Start address (byte address) |
| cmd_len | input | 7 | Number of bytes to write (1..64) |
| poll_mode | input | 1 | Completion method: 0 ready/busy, 1 data polling |
| wdat | input | 8 | Current write byte from host |
| wdat_take | output | 1 | Pulse: byte on `wdat` was latched |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 8 | Read data |
| rsp_err | output | 1 | Rejected command or program timeout |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 13 | Memory address |
| mem_dq_o | output | 8 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Data from memory |
| mem_rdy | input | 1 | Ready/busy line (pulled up, high = ready) |

## Verification
Several properties are checked on every cycle: that the controller never drives the data bus while OE is low or too soon after it rises, that WE goes low only inside a driven write cycle, that the page row stays fixed through a burst, that a bad length gets an immediate error response, and that responses are single pulses. The bench's scenarios are needed to show that write data reaches the right columns after wrapping, and that reads return stored bytes. They also show that completion waits for the memory in both ready/busy and polling modes, and that a memory that stays busy too long produces a timeout error followed by a return to idle.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_RD_FLT, S_WR_SET, S_WR_PUL, S_WR_HLD,
    S_WT_RB, S_PL_RD, S_PL_GAP, S_RSP
  } ctl_st_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/eep_cnt.sv
module eep_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/eep_done_det.sv
module eep_done_det (
  input  logic clk,
  input  logic rst_n,
  input  logic poll,
  input  logic rdy_async,
  input  logic smp7,
  input  logic exp7,
  output logic ok
);
  logic [1:0] rdy_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_sync_q <= 2'b00;
    else        rdy_sync_q <= {rdy_sync_q[0], rdy_async};
  end

  assign ok = poll ? (smp7 == exp7) : rdy_sync_q[1];
endmodule

// File: rtl/eep_page_ctl.sv
module eep_page_ctl
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int CLK_NS     = 8,
  parameter int T_ACC_NS   = 150,
  parameter int T_WP_NS    = 100,
  parameter int T_DF_NS    = 80,
  parameter int T_BLANK_NS = 200,
  parameter int TIMEOUT_NS = 20_000_000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic                           cmd_write,
  input  logic [ADDR_W-1:0]              cmd_addr,
  input  logic [$clog2(PAGE_BYTES):0]    cmd_len,
  input  logic                           poll_mode,
  input  logic [DATA_W-1:0]              wdat,
  output logic                           wdat_take,
  output logic                           rsp_valid,
  output logic [DATA_W-1:0]              rsp_rdata,
  output logic                           rsp_err,
  output logic                           mem_ce_n,
  output logic                           mem_oe_n,
  output logic                           mem_we_n,
  output logic [ADDR_W-1:0]              mem_addr,
  output logic [DATA_W-1:0]              mem_dq_o,
  output logic                           mem_dq_oe,
  input  logic [DATA_W-1:0]              mem_dq_i,
  input  logic                           mem_rdy
);
  localparam int COL_W   = $clog2(PAGE_BYTES);
  localparam int LEN_W   = COL_W + 1;
  localparam int RD_CYC  = int'(ns2cyc(T_ACC_NS, CLK_NS)) + 1;
  localparam int WP_CYC  = int'(ns2cyc(T_WP_NS, CLK_NS));
  localparam int FLT_CYC = int'(ns2cyc(T_DF_NS, CLK_NS));
  localparam int BLK_CYC = int'(ns2cyc(T_BLANK_NS, CLK_NS)) + 2;
  localparam int TMO_CYC = int'(ns2cyc(TIMEOUT_NS, CLK_NS));
  localparam int PH_MAX  = (RD_CYC > WP_CYC ? RD_CYC : WP_CYC) > (FLT_CYC > BLK_CYC ? FLT_CYC : BLK_CYC)
                         ? (RD_CYC > WP_CYC ? RD_CYC : WP_CYC) : (FLT_CYC > BLK_CYC ? FLT_CYC : BLK_CYC);
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int TMO_W   = $clog2(TMO_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ctl_st_e             st_q, st_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [LEN_W-1:0]    left_q, left_d;
  logic [DATA_W-1:0]   dout_q, dout_d, rdata_q, rdata_d;
  logic                exp7_q, exp7_d, poll_q, poll_d, smp7_q, smp7_d;
  logic                err_q, err_d, take_q, take_d;
  logic                ph_load, ph_zero, tmo_load, tmo_zero, done_ok;
  logic [PH_W-1:0]     ph_val;

  eep_cnt #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n_s), .load(ph_load), .val(ph_val), .zero(ph_zero));

  eep_cnt #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n_s), .load(tmo_load), .val(TMO_W'(TMO_CYC - 1)), .zero(tmo_zero));

  eep_done_det u_det (
    .clk(clk), .rst_n(rst_n_s), .poll(poll_q), .rdy_async(mem_rdy),
    .smp7(smp7_q), .exp7(exp7_q), .ok(done_ok));

  always_comb begin
    st_d = st_q;   addr_d = addr_q; left_d = left_q; dout_d = dout_q;
    rdata_d = rdata_q; exp7_d = exp7_q; poll_d = poll_q; smp7_d = smp7_q;
    err_d = err_q; take_d = 1'b0;
    ph_load = 1'b0; ph_val = '0; tmo_load = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_valid) begin
        addr_d = cmd_addr; poll_d = poll_mode; err_d = 1'b0;
        if (!cmd_write) begin
          st_d = S_RD; ph_load = 1'b1; ph_val = PH_W'(RD_CYC - 1);
        end else if (cmd_len == '0 || cmd_len > LEN_W'(PAGE_BYTES)) begin
          err_d = 1'b1; st_d = S_RSP;
        end else begin
          left_d = cmd_len; dout_d = wdat; exp7_d = wdat[DATA_W-1];
          take_d = 1'b1; st_d = S_WR_SET;
        end
      end
      S_RD: if (ph_zero) begin
        rdata_d = mem_dq_i; st_d = S_RD_FLT;
        ph_load = 1'b1; ph_val = PH_W'(FLT_CYC - 1);
      end
      S_RD_FLT: if (ph_zero) st_d = S_RSP;
      S_WR_SET: begin
        st_d = S_WR_PUL; ph_load = 1'b1; ph_val = PH_W'(WP_CYC - 1);
      end
      S_WR_PUL: if (ph_zero) st_d = S_WR_HLD;
      S_WR_HLD: if (left_q == LEN_W'(1)) begin
        tmo_load = 1'b1; ph_load = 1'b1;
        if (poll_q) begin st_d = S_PL_RD; ph_val = PH_W'(RD_CYC - 1);  end
        else        begin st_d = S_WT_RB; ph_val = PH_W'(BLK_CYC - 1); end
      end else begin
        left_d = left_q - 1'b1;
        addr_d = {addr_q[ADDR_W-1:COL_W], addr_q[COL_W-1:0] + 1'b1};
        dout_d = wdat; exp7_d = wdat[DATA_W-1]; take_d = 1'b1; st_d = S_WR_SET;
      end
      S_WT_RB: if (ph_zero) begin
        if (done_ok)       st_d = S_RSP;
        else if (tmo_zero) begin err_d = 1'b1; st_d = S_RSP; end
      end
      S_PL_RD: if (ph_zero) begin
        smp7_d = mem_dq_i[DATA_W-1]; st_d = S_PL_GAP;
        ph_load = 1'b1; ph_val = PH_W'(FLT_CYC - 1);
      end
      S_PL_GAP: if (ph_zero) begin
        if (done_ok)       st_d = S_RSP;
        else if (tmo_zero) begin err_d = 1'b1; st_d = S_RSP; end
        else begin st_d = S_PL_RD; ph_load = 1'b1; ph_val = PH_W'(RD_CYC - 1); end
      end
      S_RSP:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q <= S_IDLE; addr_q <= '0; left_q <= '0; dout_q <= '0; rdata_q <= '0;
      exp7_q <= 1'b0; poll_q <= 1'b0; smp7_q <= 1'b0; err_q <= 1'b0; take_q <= 1'b0;
    end else begin
      st_q <= st_d; addr_q <= addr_d; left_q <= left_d; dout_q <= dout_d; rdata_q <= rdata_d;
      exp7_q <= exp7_d; poll_q <= poll_d; smp7_q <= smp7_d; err_q <= err_d; take_q <= take_d;
    end
  end

  assign mem_ce_n  = !(st_q inside {S_RD, S_PL_RD, S_WR_SET, S_WR_PUL, S_WR_HLD});
  assign mem_oe_n  = !(st_q inside {S_RD, S_PL_RD});
  assign mem_we_n  = (st_q != S_WR_PUL);
  assign mem_dq_oe = (st_q inside {S_WR_SET, S_WR_PUL, S_WR_HLD});
  assign mem_addr  = addr_q;
  assign mem_dq_o  = dout_q;
  assign cmd_ready = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_RSP);
  assign rsp_rdata = rdata_q;
  assign rsp_err   = err_q;
  assign wdat_take = take_q;
endmodule

// File: rtl/eep_page_ctl_chk.sv
module eep_page_ctl_chk #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 64,
  parameter int FLT_CYC    = 10
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cmd_valid,
  input logic                          cmd_ready,
  input logic                          cmd_write,
  input logic [$clog2(PAGE_BYTES):0]   cmd_len,
  input logic                          rsp_valid,
  input logic                          rsp_err,
  input logic                          mem_ce_n,
  input logic                          mem_oe_n,
  input logic                          mem_we_n,
  input logic [ADDR_W-1:0]             mem_addr,
  input logic                          mem_dq_oe
);
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int LEN_W = COL_W + 1;
  localparam int FC_W  = $clog2(FLT_CYC + 1);

  logic [FC_W-1:0] oe_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             oe_hi_cnt <= FC_W'(FLT_CYC);
    else if (!mem_oe_n)                     oe_hi_cnt <= '0;
    else if (oe_hi_cnt < FC_W'(FLT_CYC))    oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1
  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe)); // R3
  AST_PAGE_ROW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> (mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W]))); // R4
  AST_BAD_LEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_write && (cmd_len == '0 || cmd_len > LEN_W'(PAGE_BYTES)))
      |=> (rsp_valid && rsp_err)); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R9
  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (oe_hi_cnt >= FC_W'(FLT_CYC))); // R9
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
  AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R10
endmodule

bind eep_page_ctl eep_page_ctl_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .FLT_CYC(FLT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_len(cmd_len), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/eep_page_ctl_test.sv
`timescale 1ns/1ps
module eep_page_ctl_test;
  localparam int CLK_NS   = 8;
  localparam int WP_MIN   = 13;   // ceil(100/8)
  localparam int RD_MIN   = 19;   // ceil(150/8)
  localparam int FLT_MIN  = 10;   // ceil(80/8)
  localparam int LOADWIN  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, cmd_write = 0, poll_mode = 0;
  logic [12:0] cmd_addr = '0;
  logic [6:0]  cmd_len = '0;
  logic [7:0]  wdat = '0;
  logic        cmd_ready, wdat_take, rsp_valid, rsp_err;
  logic [7:0]  rsp_rdata, mem_dq_o, mem_dq_i;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_rdy;
  logic [12:0] mem_addr;

  eep_page_ctl #(.CLK_NS(CLK_NS), .TIMEOUT_NS(8000)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .poll_mode(poll_mode),
    .wdat(wdat), .wdat_take(wdat_take), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_rdy(mem_rdy));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0] mem   [0:8191];
  logic [7:0] ref_m [0:8191];
  logic [7:0] pend  [0:63];
  bit         pend_v[0:63];
  int  win = 0, prog = 0, prog_cyc = 150;
  bit  busy = 0, loading = 0, last7 = 0;
  logic [6:0] row = '0;
  bit  prev_we = 1;

  assign mem_rdy  = !busy;
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? (busy ? {~last7, 7'h00} : mem[mem_addr]) : 8'h00;

  always @(negedge clk) begin
    if (!prev_we && mem_we_n && !mem_ce_n) begin
      if (!loading) begin
        loading = 1; row = mem_addr[12:6];
        for (int i = 0; i < 64; i++) pend_v[i] = 0;
      end else if (mem_addr[12:6] != row) begin
        fails++; checks++;
        $display("FAIL R4 page row changed in burst: actual=%0h expected=%0h", mem_addr[12:6], row);
      end
      pend[mem_addr[5:0]] = mem_dq_o; pend_v[mem_addr[5:0]] = 1;
      last7 = mem_dq_o[7]; busy = 1; win = LOADWIN;
    end else if (win > 0) begin
      win--;
      if (win == 0) begin
        for (int i = 0; i < 64; i++) if (pend_v[i]) mem[{row, 6'(i)}] = pend[i];
        loading = 0; prog = prog_cyc;
      end
    end else if (prog > 0) begin
      prog--;
      if (prog == 0) busy = 0;
    end
    prev_we = mem_we_n;
  end

  // ---------------- pin monitors ----------------
  int we_lo = 0, oe_lo = 0, oe_hi = 100, ce_falls = 0, takes = 0, widx = 0;
  bit prev_ce = 1;
  logic [7:0] wq[$];

  always @(negedge clk) begin
    if (!mem_we_n) we_lo++;
    else if (we_lo > 0) begin chk("R3", "WE pulse cycles>=min", int'(we_lo >= WP_MIN), 1); we_lo = 0; end
    if (!mem_oe_n) begin oe_lo++; oe_hi = 0; end
    else begin
      if (oe_lo > 0) begin chk("R2", "OE low cycles>=min", int'(oe_lo >= RD_MIN), 1); oe_lo = 0; end
      if (oe_hi < 100) oe_hi++;
    end
    if (mem_dq_oe && (!mem_oe_n || oe_hi <= FLT_MIN)) begin
      fails++; checks++;
      $display("FAIL R9 bus driven too early: actual=%0d expected>%0d", oe_hi, FLT_MIN);
    end
    if (prev_ce && !mem_ce_n) ce_falls++;
    prev_ce = mem_ce_n;
    if (wdat_take) begin
      takes++; widx++;
      if (widx < wq.size()) wdat = wq[widx];
    end
  end

  // ---------------- command driver ----------------
  bit r_err; logic [7:0] r_dat; bit busy_at_rsp;

  task automatic send(input bit wr, input logic [12:0] a, input logic [6:0] len, input bit pm);
    int n;
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_len = len; poll_mode = pm;
    n = 0;
    while (!cmd_ready && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk);
    cmd_valid = 0;
    n = 0;
    while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
    chk("R10", "response seen", int'(rsp_valid), 1);
    r_err = rsp_err; r_dat = rsp_rdata; busy_at_rsp = busy;
    @(negedge clk);
    chk("R10", "single pulse / ready after rsp", int'({rsp_valid, cmd_ready}), 1);
  endtask

  task automatic write_page(input logic [12:0] a, input int len, input bit pm, input int seed);
    wq.delete();
    for (int i = 0; i < len; i++) wq.push_back(8'((seed + i * 37) ^ (i << 3)));
    widx = 0; takes = 0; wdat = wq[0];
    send(1, a, 7'(len), pm);
    for (int i = 0; i < len; i++) ref_m[{a[12:6], 6'(a[5:0] + 6'(i))}] = wq[i];
  endtask

  task automatic read_chk(input logic [12:0] a, input string req);
    send(0, a, 7'd1, 0);
    chk(req, "read data", int'(r_dat), int'(ref_m[a]));
    chk(req, "read err", int'(r_err), 0);
  endtask

  task automatic wait_idle_mem();
    int n = 0;
    while (busy && n < 10000) begin @(negedge clk); n++; end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    int cf;
    for (int i = 0; i < 8192; i++) begin mem[i] = 8'(i ^ (i >> 5)); ref_m[i] = mem[i]; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pins during reset", int'({cmd_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}), 6'b111100);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", "pins after reset", int'({cmd_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}), 6'b111100);

    // R2 read of untouched location
    read_chk(13'h0123, "R2");

    // R6 ready/busy completion, 4 bytes
    write_page(13'h0104, 4, 0, 8'hA5);
    chk("R6", "rb write err", int'(r_err), 0);
    chk("R6", "memory ready at rsp", int'(busy_at_rsp), 0);
    chk("R3", "take count", takes, 4);
    for (int i = 0; i < 4; i++) read_chk(13'h0104 + 13'(i), "R2");

    // R7 + R4 polling, full page starting at column 60
    write_page(13'h1F7C, 64, 1, 8'h3C);
    chk("R7", "poll write err", int'(r_err), 0);
    chk("R7", "memory ready at rsp", int'(busy_at_rsp), 0);
    chk("R3", "take count 64", takes, 64);
    read_chk(13'h1F7C, "R4");
    read_chk(13'h1F7F, "R4");
    read_chk(13'h1F40, "R4");
    read_chk(13'h1F7B, "R4");
    read_chk(13'h1F80, "R4");   // next row untouched

    // R7 single byte with bit7 = 1
    wq.delete(); wq.push_back(8'h80); widx = 0; takes = 0; wdat = 8'h80;
    send(1, 13'h0000, 7'd1, 1);
    ref_m[0] = 8'h80;
    chk("R7", "bit7=1 poll err", int'(r_err), 0);
    chk("R7", "memory ready at rsp", int'(busy_at_rsp), 0);
    read_chk(13'h0000, "R7");

    // R5 rejected lengths
    cf = ce_falls;
    send(1, 13'h0200, 7'd0, 0);
    chk("R5", "len 0 err", int'(r_err), 1);
    send(1, 13'h0200, 7'd65, 1);
    chk("R5", "len 65 err", int'(r_err), 1);
    chk("R5", "no CE activity", ce_falls, cf);
    read_chk(13'h0200, "R5");

    // R8 timeout, ready/busy and polling
    prog_cyc = 3000;
    write_page(13'h0A00, 2, 0, 8'h11);
    chk("R8", "rb timeout err", int'(r_err), 1);
    chk("R8", "memory still busy", int'(busy_at_rsp), 1);
    wait_idle_mem();
    write_page(13'h0A40, 3, 1, 8'h92);
    chk("R8", "poll timeout err", int'(r_err), 1);
    chk("R8", "idle after timeout", int'(cmd_ready), 1);
    wait_idle_mem();
    prog_cyc = 150;
    read_chk(13'h0A41, "R8");

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule